// File: doc/BRIEF.md
# Sampled Position/Velocity Readout Port

This block freezes a live shaft angle and a live shaft speed into two holding registers when a sample strobe falls. It then hands one of the two words to a host. In parallel mode the word goes out on a bus that is driven only during a read. In serial mode a 16-bit frame is shifted out on a single data line. An external serial clock paces the shift, and the read strobe marks the start of the frame. The frame carries the data word, a bit that echoes which word was chosen, two fault flags and an odd-parity bit.

The sample, read and serial clock strobes come from outside the system clock domain. Each one passes through a multi-flop synchronizer, and the block acts on edges of the synchronized versions. The angle is unsigned, with zero meaning 0 degrees. The speed is two's complement, and its MSB gives the direction of rotation. The read falling edge fixes the frame contents, including parity and the fault flags, so the frame cannot change while it is being shifted. The interfaces are plain strobes. There is no valid/ready handshake, and the host paces every transfer.

Top module: `pv_readout`

## Requirements
- R1: After reset, both holding registers, the output buffer and the serial frame are zero. All bus enables are low and `sdo` is low.
- R2: A falling edge on `smp_n` copies `ang_in` into the position holding register and `vel_in` into the velocity holding register. Changing the inputs without such an edge leaves both registers unchanged.
- R3: `sel_pos` = 1 selects the position word and `sel_pos` = 0 selects the velocity word for the next read.
- R4: In parallel mode (`par_mode` = 1), all bits of `pbus_oe` are 1 exactly when `cs_n` is low and the synchronized read is low. Otherwise all bits are 0, and `pbus_q` then carries the output buffer.
- R5: A falling edge on `rd_n` while `cs_n` is low loads the selected word into the output buffer. Later changes of `sel_pos` while read stays low do not alter the bus.
- R6: In serial mode (`par_mode` = 0), `pbus_oe` bits DATA_W-3..0 and bit DATA_W-2 are 0. Bit DATA_W-1 is 1 while `cs_n` is low, and `pbus_q[DATA_W-1]` equals `sdo`.
- R7: The serial frame is {data word in bits 15..4, select echo in bit 3 (1 = position), `deg_flag` in bit 2, `trk_flag` in bit 1, parity in bit 0}. It is sent MSB first.
- R8: The parity bit makes the 16-bit frame hold an odd number of ones.
- R9: Frame bit 15 is on `sdo` after the read falling edge and before any serial clock pulse. Each rising `sclk` edge, while `cs_n` and read are low, moves the next lower bit onto `sdo`.
- R10: Once all 16 bits have been sent, further rising `sclk` edges while read stays low put zeros on `sdo`.
- R11: A falling edge on `rd_n` while `cs_n` is high does not load the output buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ang_in | input | DATA_W | Live angle, unsigned |
| vel_in | input | DATA_W | Live speed, two's complement |
| deg_flag | input | 1 | Signal-degradation fault flag, placed in frame bit 2 |
| trk_flag | input | 1 | Tracking-loss fault flag, placed in frame bit 1 |
| smp_n | input | 1 | Sample strobe; a falling edge captures both words |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe; a falling edge loads the buffer and starts a frame |
| sel_pos | input | 1 | 1 = position, 0 = velocity |
| par_mode | input | 1 | 1 = parallel bus, 0 = serial |
| sclk | input | 1 | Serial shift clock |
| pbus_q | output | DATA_W | Bus data |
| pbus_oe | output | DATA_W | Per-line output enable |
| sdo | output | 1 | Serial data out |

## Verification
The bench builds the block with DATA_W = 12 and SYNC_STAGES = 2, which gives the 16-bit frame. The stimulus table covers the extreme codes: all ones, all zeros, and the most negative and most positive speeds. Each table row is read twice, once over the bus and once as a full serial frame, with the fault flags varied, so that every parity case and both select echoes appear. Extra clock pulses at the end of each frame reach the zero-fill behaviour. Directed cases cover bus gating by select and read, a select change during a held read, a read edge with select deasserted, and input changes with no sample edge.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  // Number of frame bits beyond the data word: select echo, two flags, parity.
  localparam int unsigned TAG_BITS = 4;

  typedef enum logic {
    WORD_VEL = 1'b0,
    WORD_POS = 1'b1
  } word_sel_e;

  typedef enum logic {
    PORT_SERIAL   = 1'b0,
    PORT_PARALLEL = 1'b1
  } port_mode_e;
endpackage

// File: rtl/pvr_sync.sv
// Multi-flop synchronizer that also keeps the previous synchronized level,
// so the parent can form either edge.
module pvr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prv
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= {STAGES{IDLE}};
      prv   <= IDLE;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prv <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/pvr_hold.sv
// Position and velocity holding registers, written on a capture pulse.
module pvr_hold #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] ang,
  input  logic [DW-1:0] vel,
  output logic [DW-1:0] pos_q,
  output logic [DW-1:0] vel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      vel_q <= '0;
    end else if (cap) begin
      pos_q <= ang;
      vel_q <= vel;
    end
  end
endmodule

// File: rtl/pvr_shifter.sv
// Frame register: parallel load, MSB-first shift with zero fill.
module pvr_shifter #(
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [FW-1:0] din,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[FW-2:0], 1'b0};
  end
endmodule

// File: rtl/pv_readout.sv
module pv_readout #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ang_in,
  input  logic [DATA_W-1:0] vel_in,
  input  logic              deg_flag,
  input  logic              trk_flag,
  input  logic              smp_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sel_pos,
  input  logic              par_mode,
  input  logic              sclk,
  output logic [DATA_W-1:0] pbus_q,
  output logic [DATA_W-1:0] pbus_oe,
  output logic              sdo
);
  import pvr_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + TAG_BITS;
  localparam int unsigned LOW_W   = DATA_W - 2;

  logic smp_s, smp_p, rd_s, rd_p, sclk_s, sclk_p;
  logic smp_fall, rd_fall, sclk_rise, ld_en, sh_en;
  logic [DATA_W-1:0]  pos_q, vel_q, sel_word, obuf_q;
  logic [FRAME_W-1:0] frm_d, frm_q;
  logic               par_bit;

  pvr_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_smp_sync (
    .clk(clk), .rst_n(rst_n), .din(smp_n), .lvl(smp_s), .prv(smp_p));
  pvr_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .din(rd_n), .lvl(rd_s), .prv(rd_p));
  pvr_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk), .lvl(sclk_s), .prv(sclk_p));

  assign smp_fall  = smp_p & ~smp_s;
  assign rd_fall   = rd_p & ~rd_s;
  assign sclk_rise = sclk_s & ~sclk_p;
  assign ld_en     = rd_fall & ~cs_n;
  assign sh_en     = sclk_rise & ~rd_s & ~cs_n & ~ld_en;

  pvr_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(smp_fall),
    .ang(ang_in), .vel(vel_in), .pos_q(pos_q), .vel_q(vel_q));

  assign sel_word = (sel_pos == WORD_POS) ? pos_q : vel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     obuf_q <= '0;
    else if (ld_en) obuf_q <= sel_word;
  end

  assign par_bit = ~^{sel_word, sel_pos, deg_flag, trk_flag};
  assign frm_d   = {sel_word, sel_pos, deg_flag, trk_flag, par_bit};

  pvr_shifter #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld_en), .shift(sh_en),
    .din(frm_d), .q(frm_q));

  assign sdo = frm_q[FRAME_W-1];

  always_comb begin
    if (par_mode == PORT_PARALLEL) begin
      pbus_q  = obuf_q;
      pbus_oe = {DATA_W{~cs_n & ~rd_s}};
    end else begin
      pbus_q  = {sdo, {(DATA_W-1){1'b0}}};
      pbus_oe = {~cs_n, 1'b0, {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/pv_readout_chk.sv
module pv_readout_chk #(
  parameter int unsigned DW = 12,
  parameter int unsigned FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          par_mode,
  input logic          smp_fall,
  input logic          ld_en,
  input logic          sh_en,
  input logic [DW-1:0] pos_q,
  input logic [DW-1:0] vel_q,
  input logic [DW-1:0] obuf_q,
  input logic [FW-1:0] frm_q,
  input logic [DW-1:0] pbus_oe,
  input logic          sdo
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_fall |=> ($stable(pos_q) && $stable(vel_q)));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (pbus_oe == '0));

  assert_buf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(obuf_q));

  assert_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |-> (pbus_oe[DW-2:0] == '0));

  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (^frm_q));

  assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> (sdo == $past(frm_q[FW-2])));

  assert_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> !frm_q[0]);
endmodule

bind pv_readout pv_readout_chk #(.DW(DATA_W), .FW(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .par_mode(par_mode),
  .smp_fall(smp_fall), .ld_en(ld_en), .sh_en(sh_en),
  .pos_q(pos_q), .vel_q(vel_q), .obuf_q(obuf_q), .frm_q(frm_q),
  .pbus_oe(pbus_oe), .sdo(sdo));

// File: tb/pv_readout_test.sv
module pv_readout_test;
  localparam int DW = 12;
  localparam int FW = 16;
  localparam int NV = 6;
  // {ang, vel, sel, deg, trk}
  localparam logic [26:0] VEC [0:NV-1] = '{
    {12'h000, 12'h7FF, 1'b1, 1'b0, 1'b0},
    {12'hFFF, 12'h800, 1'b0, 1'b1, 1'b0},
    {12'hA5C, 12'h001, 1'b1, 1'b0, 1'b1},
    {12'h3C3, 12'hFFE, 1'b0, 1'b1, 1'b1},
    {12'h801, 12'h123, 1'b1, 1'b1, 1'b1},
    {12'h7FE, 12'h000, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] ang_in = '0, vel_in = '0;
  logic deg_flag = 0, trk_flag = 0, smp_n = 1, cs_n = 1, rd_n = 1;
  logic sel_pos = 1, par_mode = 1, sclk = 1;
  logic [DW-1:0] pbus_q, pbus_oe;
  logic sdo;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  pv_readout #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ang_in(ang_in), .vel_in(vel_in),
    .deg_flag(deg_flag), .trk_flag(trk_flag), .smp_n(smp_n), .cs_n(cs_n),
    .rd_n(rd_n), .sel_pos(sel_pos), .par_mode(par_mode), .sclk(sclk),
    .pbus_q(pbus_q), .pbus_oe(pbus_oe), .sdo(sdo));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_sample();
    smp_n = 0; step(6);
    smp_n = 1; step(6);
  endtask

  task automatic par_read(output logic [DW-1:0] w);
    par_mode = 1; cs_n = 0; rd_n = 0; step(6);
    chk("R4 enables during read", pbus_oe, {DW{1'b1}});
    w = pbus_q;
    rd_n = 1; step(6);
    cs_n = 1; step(2);
  endtask

  task automatic ser_read(output logic [FW-1:0] f);
    par_mode = 0; sclk = 1; cs_n = 0; rd_n = 0; step(6);
    f[FW-1] = sdo;
    for (int i = FW - 2; i >= 0; i--) begin
      sclk = 0; step(6);
      sclk = 1; step(6);
      f[i] = sdo;
    end
    for (int k = 0; k < 3; k++) begin
      sclk = 0; step(6);
      sclk = 1; step(6);
      chk("R10 zero fill", sdo, 0);
    end
    rd_n = 1; step(6);
    cs_n = 1; step(2);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [DW-1:0] w, ew;
    logic [FW-1:0] f, ef;
    logic [DW-1:0] a, v;
    logic s, d, t;
    step(5);
    // R1: reset state
    chk("R1 oe", pbus_oe, 0);
    chk("R1 sdo", sdo, 0);
    rst_n = 1; step(3);
    sel_pos = 1; par_read(w); chk("R1 pos reg", w, 0);
    sel_pos = 0; par_read(w); chk("R1 vel reg", w, 0);

    for (int n = 0; n < NV; n++) begin
      {a, v, s, d, t} = VEC[n];
      ang_in = a; vel_in = v; sel_pos = s; deg_flag = d; trk_flag = t;
      do_sample();
      ew = s ? a : v;
      par_read(w);
      chk("R3 selected word", w, ew);
      ef = {ew, s, d, t, ~^{ew, s, d, t}};
      ser_read(f);
      chk("R7 frame layout / R9 order", f, ef);
      chk("R8 odd parity", ^f, 1);
    end

    // R2: no sample edge, no change
    ang_in = 12'h155; vel_in = 12'h2AA; sel_pos = 1; step(4);
    par_read(w); chk("R2 pos held", w, 12'h7FE);
    do_sample();
    par_read(w); chk("R2 pos captured", w, 12'h155);
    sel_pos = 0; par_read(w); chk("R2 vel captured", w, 12'h2AA);

    // R4: gating in parallel mode
    par_mode = 1; cs_n = 1; rd_n = 0; step(6);
    chk("R4 cs high", pbus_oe, 0);
    rd_n = 1; cs_n = 0; step(6);
    chk("R4 rd high", pbus_oe, 0);
    cs_n = 1; step(2);

    // R5: select change while read held low
    sel_pos = 1; cs_n = 0; rd_n = 0; step(6);
    sel_pos = 0; step(6);
    chk("R5 buffer held", pbus_q, 12'h155);
    rd_n = 1; step(6); cs_n = 1; step(2);

    // R11: read edge with chip select high does not load
    sel_pos = 0; cs_n = 1; rd_n = 0; step(6);
    cs_n = 0; step(6);
    chk("R11 no load", pbus_q, 12'h155);
    rd_n = 1; step(6); cs_n = 1; step(2);

    // R6: serial mode pin roles
    par_mode = 0; sel_pos = 1; deg_flag = 0; trk_flag = 0; cs_n = 0; step(2);
    rd_n = 0; step(6);
    chk("R6 serial enables", pbus_oe, {1'b1, {(DW-1){1'b0}}});
    chk("R6 serial line", pbus_q[DW-1], sdo);
    chk("R9 msb before clock", sdo, 0);
    rd_n = 1; step(6); cs_n = 1; step(2);
    chk("R6 serial cs high", pbus_oe, 0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule